// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Unit

This block holds the hazard control for a five-stage in-order integer pipeline. It takes the decoded register fields of the instruction sitting in decode. It pushes the destination information down through its own execute, memory and writeback control registers. For the instruction in execute, it decides where each ALU operand comes from. It then delivers that operand value. There are four possible sources. The first is the register-file read. The second is the ALU result held after execute. The third is the ALU result held after the memory stage. The fourth is the data returned by a load in the memory stage.

One case cannot be covered by bypassing: a load followed at once by an instruction that reads the load's destination. For this case the unit raises a stall for exactly one cycle. The surrounding pipeline must then hold its PC and decode register. The unit itself loads an all-zero bubble into its execute control register, and bypassing covers the dependency after that.

A parameter selects a build with no bypass paths. In that build any dependency on an instruction still in execute or memory interlocks. A dependency on a writeback-stage producer needs no action, because the register file writes early in the cycle and reads late.

Top module: `hz_fwd_unit`

## Requirements
- R1: After synchronous reset, `stall` is 0, `ex_we` is 0, and both operand selects read 0 (register file).
- R2: Select encoding is 0 = register file, 1 = execute-result ALU value, 2 = memory-stage ALU value, 3 = memory-stage load data. When the instruction one ahead writes a used source register, that operand selects 1 and `op_a`/`op_b` equal `exmem_alu`.
- R3: When the producer is two ahead and is not a load, the operand selects 2 and carries `memwb_alu`.
- R4: When the producer two ahead is a load, the operand selects 3 and carries `memwb_load`.
- R5: A load in execute whose destination is a used source of the decode instruction raises `stall` for exactly one cycle.
- R6: In the cycle after a stall, the execute control register holds a bubble (`ex_we` = 0, `ex_rd` = 0).
- R7: When both the producer one ahead and the producer two ahead write the same source register, the one ahead wins (select 1).
- R8: Register 0 never matches. A source of 0 selects the register file, its operand value is 0 whatever `rf_a`/`rf_b` carry, and a load to register 0 causes no stall.
- R9: A producer three ahead (in writeback while the consumer decodes) causes no stall and no bypass; the register-file value is used.
- R10: A source whose use flag is 0 causes no stall and no bypass, even if its number matches a pending load.
- R11: With `FORWARD` = 0, a dependent instruction right after an ALU producer stalls for exactly two cycles, and the selects stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | 5 | First source register of the decode instruction |
| id_rs2 | input | 5 | Second source register of the decode instruction |
| id_use1 | input | 1 | First source is read |
| id_use2 | input | 1 | Second source is read |
| id_rd | input | 5 | Destination register of the decode instruction |
| id_we | input | 1 | Decode instruction writes a register |
| id_ld | input | 1 | Decode instruction is a load |
| rf_a | input | XLEN | Register-file value of first source, execute instruction |
| rf_b | input | XLEN | Register-file value of second source, execute instruction |
| exmem_alu | input | XLEN | ALU result held after execute |
| memwb_alu | input | XLEN | ALU result held after memory stage |
| memwb_load | input | XLEN | Load data held after memory stage |
| stall | output | 1 | Freeze PC and decode register; bubble goes to execute |
| sel_a | output | 2 | Source select of operand A |
| sel_b | output | 2 | Source select of operand B |
| op_a | output | XLEN | Operand A value |
| op_b | output | XLEN | Operand B value |
| ex_we | output | 1 | Execute-stage instruction writes a register |
| ex_rd | output | 5 | Execute-stage destination register |

## Verification
The assertions assume that the surrounding pipeline obeys `stall`. The decode fields must stay unchanged during the cycle that follows a stall, so that the dependent instruction is still waiting when the load reaches the memory stage. Under that assumption a load in the memory stage is never chosen as an execute-result bypass. The directed stimulus keeps within this assumption by re-driving the same decode instruction across every stall cycle. It inserts no-operation flushes between scenarios so that no stale producer leaks into the next one.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int RA_W = 5;

    typedef logic [RA_W-1:0] ridx_t;

    typedef enum logic [1:0] {
        SEL_RF         = 2'd0,
        SEL_EXMEM_ALU  = 2'd1,
        SEL_MEMWB_ALU  = 2'd2,
        SEL_MEMWB_LOAD = 2'd3
    } opsel_e;

    // decoded fields that travel from decode into execute
    typedef struct packed {
        ridx_t rs1;
        ridx_t rs2;
        logic  use1;
        logic  use2;
        ridx_t rd;
        logic  we;
        logic  ld;
    } dec_t;

    // destination information carried further down the pipe
    typedef struct packed {
        ridx_t rd;
        logic  we;
        logic  ld;
    } dst_t;

    function automatic logic dst_hits(dst_t d, ridx_t r);
        return d.we && (d.rd != '0) && (d.rd == r);
    endfunction

    function automatic dst_t to_dst(dec_t x);
        dst_t d;
        d.rd = x.rd;
        d.we = x.we;
        d.ld = x.ld;
        return d;
    endfunction

endpackage

// File: rtl/hz_ctl_pipe.sv
module hz_ctl_pipe
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stall,
    input  dec_t id_dec,
    output dec_t ex_q,
    output dst_t mem_q,
    output dst_t wb_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q  <= '0;
            mem_q <= '0;
            wb_q  <= '0;
        end else begin
            ex_q  <= stall ? dec_t'('0) : id_dec;
            mem_q <= to_dst(ex_q);
            wb_q  <= mem_q;
        end
    end

    AST_BUBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        stall |=> (ex_q.we == 1'b0 && ex_q.rd == '0 && ex_q.ld == 1'b0)); // R6

    AST_DST_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (wb_q == $past(mem_q))); // R3

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter bit FORWARD = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  ridx_t id_rs1,
    input  ridx_t id_rs2,
    input  logic  id_use1,
    input  logic  id_use2,
    input  dst_t  ex_d,
    input  dst_t  mem_d,
    output logic  stall
);

    logic hit_ex;
    logic hit_mem;

    always_comb begin
        hit_ex  = (id_use1 && dst_hits(ex_d,  id_rs1)) ||
                  (id_use2 && dst_hits(ex_d,  id_rs2));
        hit_mem = (id_use1 && dst_hits(mem_d, id_rs1)) ||
                  (id_use2 && dst_hits(mem_d, id_rs2));
    end

    generate
        if (FORWARD) begin : g_bypass
            // only a load one ahead cannot be covered by a bypass
            assign stall = hit_ex && ex_d.ld;

            AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
                stall |=> !stall); // R5

            AST_HELD_DEP_IN_MEM: assert property (@(posedge clk) disable iff (rst)
                stall |=> (hit_mem && mem_d.ld)); // R5
        end else begin : g_nobypass
            // any producer not yet in writeback blocks the consumer
            assign stall = hit_ex || hit_mem;
        end
    endgenerate

endmodule

// File: rtl/hz_bypass.sv
module hz_bypass
    import hz_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit FORWARD = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  ridx_t           src,
    input  logic            src_use,
    input  dst_t            mem_d,
    input  dst_t            wb_d,
    input  logic [XLEN-1:0] rf_val,
    input  logic [XLEN-1:0] exmem_alu,
    input  logic [XLEN-1:0] memwb_alu,
    input  logic [XLEN-1:0] memwb_load,
    output opsel_e          sel,
    output logic [XLEN-1:0] val
);

    generate
        if (FORWARD) begin : g_fwd
            always_comb begin
                if (!src_use || src == '0)
                    sel = SEL_RF;
                else if (dst_hits(mem_d, src))
                    sel = SEL_EXMEM_ALU;      // younger producer wins
                else if (dst_hits(wb_d, src))
                    sel = wb_d.ld ? SEL_MEMWB_LOAD : SEL_MEMWB_ALU;
                else
                    sel = SEL_RF;
            end
        end else begin : g_rf_only
            assign sel = SEL_RF;
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_EXMEM_ALU:  val = exmem_alu;
            SEL_MEMWB_ALU:  val = memwb_alu;
            SEL_MEMWB_LOAD: val = memwb_load;
            default:        val = (src == '0) ? '0 : rf_val;
        endcase
    end

    AST_ZERO_REG_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> (sel == SEL_RF && val == '0)); // R8

    AST_NO_EXMEM_LOAD: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_EXMEM_ALU) |-> !mem_d.ld); // R5

    AST_UNUSED_SRC_RF: assert property (@(posedge clk) disable iff (rst)
        !src_use |-> (sel == SEL_RF)); // R10

endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
    import hz_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit FORWARD = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RA_W-1:0]      id_rs1,
    input  logic [RA_W-1:0]      id_rs2,
    input  logic                 id_use1,
    input  logic                 id_use2,
    input  logic [RA_W-1:0]      id_rd,
    input  logic                 id_we,
    input  logic                 id_ld,
    input  logic [XLEN-1:0]      rf_a,
    input  logic [XLEN-1:0]      rf_b,
    input  logic [XLEN-1:0]      exmem_alu,
    input  logic [XLEN-1:0]      memwb_alu,
    input  logic [XLEN-1:0]      memwb_load,
    output logic                 stall,
    output logic [1:0]           sel_a,
    output logic [1:0]           sel_b,
    output logic [XLEN-1:0]      op_a,
    output logic [XLEN-1:0]      op_b,
    output logic                 ex_we,
    output logic [RA_W-1:0]      ex_rd
);

    localparam int NOPS = 2;

    dec_t id_dec;
    dec_t ex_q;
    dst_t mem_q;
    dst_t wb_q;

    always_comb begin
        id_dec.rs1  = id_rs1;
        id_dec.rs2  = id_rs2;
        id_dec.use1 = id_use1;
        id_dec.use2 = id_use2;
        id_dec.rd   = id_rd;
        id_dec.we   = id_we;
        id_dec.ld   = id_ld;
    end

    hz_ctl_pipe i_pipe (
        .clk    (clk),
        .rst    (rst),
        .stall  (stall),
        .id_dec (id_dec),
        .ex_q   (ex_q),
        .mem_q  (mem_q),
        .wb_q   (wb_q)
    );

    hz_interlock #(.FORWARD(FORWARD)) i_lock (
        .clk     (clk),
        .rst     (rst),
        .id_rs1  (id_rs1),
        .id_rs2  (id_rs2),
        .id_use1 (id_use1),
        .id_use2 (id_use2),
        .ex_d    (to_dst(ex_q)),
        .mem_d   (mem_q),
        .stall   (stall)
    );

    ridx_t           src_v [NOPS];
    logic            use_v [NOPS];
    logic [XLEN-1:0] rf_v  [NOPS];
    logic [XLEN-1:0] op_v  [NOPS];
    opsel_e          sel_v [NOPS];

    always_comb begin
        src_v[0] = ex_q.rs1;
        src_v[1] = ex_q.rs2;
        use_v[0] = ex_q.use1;
        use_v[1] = ex_q.use2;
        rf_v[0]  = rf_a;
        rf_v[1]  = rf_b;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        hz_bypass #(.XLEN(XLEN), .FORWARD(FORWARD)) i_byp (
            .clk        (clk),
            .rst        (rst),
            .src        (src_v[g]),
            .src_use    (use_v[g]),
            .mem_d      (mem_q),
            .wb_d       (wb_q),
            .rf_val     (rf_v[g]),
            .exmem_alu  (exmem_alu),
            .memwb_alu  (memwb_alu),
            .memwb_load (memwb_load),
            .sel        (sel_v[g]),
            .val        (op_v[g])
        );
    end

    assign sel_a = sel_v[0];
    assign sel_b = sel_v[1];
    assign op_a  = op_v[0];
    assign op_b  = op_v[1];
    assign ex_we = ex_q.we;
    assign ex_rd = ex_q.rd;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!ex_we && sel_a == 2'd0 && sel_b == 2'd0)); // R1

    AST_STALL_BUBBLE_PORT: assert property (@(posedge clk) disable iff (rst)
        stall |=> (!ex_we && ex_rd == '0)); // R6

endmodule

// File: tb/test_hz_fwd_unit.sv
module test_hz_fwd_unit;

    localparam int CLK_P = 10;
    localparam int XLEN  = 32;

    localparam logic [31:0] V_RF_A = 32'h1111_1111;
    localparam logic [31:0] V_RF_B = 32'h5555_5555;
    localparam logic [31:0] V_EXM  = 32'h2222_2222;
    localparam logic [31:0] V_WBA  = 32'h3333_3333;
    localparam logic [31:0] V_WBL  = 32'h4444_4444;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
    logic id_use1 = 1'b0, id_use2 = 1'b0, id_we = 1'b0, id_ld = 1'b0;
    logic [XLEN-1:0] rf_a = V_RF_A, rf_b = V_RF_B;
    logic [XLEN-1:0] exmem_alu = V_EXM, memwb_alu = V_WBA, memwb_load = V_WBL;

    logic stall, ex_we;
    logic [1:0] sel_a, sel_b;
    logic [XLEN-1:0] op_a, op_b;
    logic [4:0] ex_rd;

    logic nf_stall, nf_we;
    logic [1:0] nf_sel_a, nf_sel_b;
    logic [XLEN-1:0] nf_op_a, nf_op_b;
    logic [4:0] nf_rd;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    hz_fwd_unit #(.XLEN(XLEN), .FORWARD(1'b1)) i_hz_fwd_unit (
        .clk(clk), .rst(rst),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use1(id_use1), .id_use2(id_use2),
        .id_rd(id_rd), .id_we(id_we), .id_ld(id_ld),
        .rf_a(rf_a), .rf_b(rf_b), .exmem_alu(exmem_alu),
        .memwb_alu(memwb_alu), .memwb_load(memwb_load),
        .stall(stall), .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b),
        .ex_we(ex_we), .ex_rd(ex_rd)
    );

    hz_fwd_unit #(.XLEN(XLEN), .FORWARD(1'b0)) i_hz_fwd_unit_nofwd (
        .clk(clk), .rst(rst),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use1(id_use1), .id_use2(id_use2),
        .id_rd(id_rd), .id_we(id_we), .id_ld(id_ld),
        .rf_a(rf_a), .rf_b(rf_b), .exmem_alu(exmem_alu),
        .memwb_alu(memwb_alu), .memwb_load(memwb_load),
        .stall(nf_stall), .sel_a(nf_sel_a), .sel_b(nf_sel_b), .op_a(nf_op_a),
        .op_b(nf_op_b), .ex_we(nf_we), .ex_rd(nf_rd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive a decode instruction half a cycle before the capturing edge
    task automatic drv(input logic [4:0] rs1, input logic [4:0] rs2, input logic u1,
                       input logic u2, input logic [4:0] rd, input logic we, input logic ld);
        @(negedge clk);
        id_rs1 = rs1; id_rs2 = rs2; id_use1 = u1; id_use2 = u2;
        id_rd = rd; id_we = we; id_ld = ld;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic nop();
        drv(5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) begin
            nop();
            tick();
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 stall after reset", {31'd0, stall}, 32'd0);
        chk("R1 ex_we after reset", {31'd0, ex_we}, 32'd0);
        chk("R1 sel_a after reset", {30'd0, sel_a}, 32'd0);
        chk("R1 sel_b after reset", {30'd0, sel_b}, 32'd0);
    endtask

    task automatic t_exmem_alu();
        flush();
        drv(5'd1, 5'd2, 1'b1, 1'b1, 5'd5, 1'b1, 1'b0);
        tick();
        drv(5'd5, 5'd3, 1'b1, 1'b1, 5'd6, 1'b1, 1'b0);
        chk("R2 no stall on alu producer", {31'd0, stall}, 32'd0);
        tick();
        chk("R2 sel_a one ahead", {30'd0, sel_a}, 32'd1);
        chk("R2 op_a value", op_a, V_EXM);
        chk("R2 sel_b untouched", {30'd0, sel_b}, 32'd0);
        chk("R2 op_b regfile", op_b, V_RF_B);
    endtask

    task automatic t_memwb_alu();
        flush();
        drv(5'd1, 5'd2, 1'b1, 1'b1, 5'd6, 1'b1, 1'b0);
        tick();
        nop(); tick();
        drv(5'd4, 5'd6, 1'b1, 1'b1, 5'd7, 1'b1, 1'b0);
        tick();
        chk("R3 sel_b two ahead", {30'd0, sel_b}, 32'd2);
        chk("R3 op_b value", op_b, V_WBA);
    endtask

    task automatic t_memwb_load();
        flush();
        drv(5'd1, 5'd0, 1'b1, 1'b0, 5'd11, 1'b1, 1'b1);
        tick();
        nop(); tick();
        drv(5'd11, 5'd0, 1'b1, 1'b0, 5'd3, 1'b1, 1'b0);
        tick();
        chk("R4 sel_a load two ahead", {30'd0, sel_a}, 32'd3);
        chk("R4 op_a value", op_a, V_WBL);
    endtask

    task automatic t_load_use();
        flush();
        drv(5'd1, 5'd0, 1'b1, 1'b0, 5'd7, 1'b1, 1'b1);
        tick();
        drv(5'd7, 5'd2, 1'b1, 1'b1, 5'd8, 1'b1, 1'b0);
        chk("R5 load-use raises stall", {31'd0, stall}, 32'd1);
        tick();
        chk("R6 bubble ex_we", {31'd0, ex_we}, 32'd0);
        chk("R6 bubble ex_rd", {27'd0, ex_rd}, 32'd0);
        chk("R5 stall lasts one cycle", {31'd0, stall}, 32'd0);
        tick();
        chk("R4 load bypass after bubble", {30'd0, sel_a}, 32'd3);
        chk("R4 load data after bubble", op_a, V_WBL);
        chk("R6 consumer enters execute", {27'd0, ex_rd}, 32'd8);
    endtask

    task automatic t_priority();
        flush();
        drv(5'd1, 5'd0, 1'b1, 1'b0, 5'd8, 1'b1, 1'b0);
        tick();
        drv(5'd2, 5'd0, 1'b1, 1'b0, 5'd8, 1'b1, 1'b0);
        tick();
        drv(5'd0, 5'd8, 1'b0, 1'b1, 5'd9, 1'b1, 1'b0);
        tick();
        chk("R7 younger producer wins", {30'd0, sel_b}, 32'd1);
        chk("R7 younger value", op_b, V_EXM);
    endtask

    task automatic t_reg_zero();
        flush();
        drv(5'd1, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b1);
        tick();
        drv(5'd0, 5'd0, 1'b1, 1'b1, 5'd4, 1'b1, 1'b0);
        chk("R8 load to r0 no stall", {31'd0, stall}, 32'd0);
        tick();
        chk("R8 sel_a r0", {30'd0, sel_a}, 32'd0);
        chk("R8 op_a reads zero", op_a, 32'd0);
        chk("R8 op_b reads zero", op_b, 32'd0);
    endtask

    task automatic t_distance3();
        flush();
        drv(5'd1, 5'd0, 1'b1, 1'b0, 5'd9, 1'b1, 1'b0);
        tick();
        nop(); tick();
        nop(); tick();
        drv(5'd0, 5'd9, 1'b0, 1'b1, 5'd2, 1'b1, 1'b0);
        chk("R9 no stall three ahead", {31'd0, stall}, 32'd0);
        tick();
        chk("R9 sel_b regfile", {30'd0, sel_b}, 32'd0);
        chk("R9 op_b regfile", op_b, V_RF_B);
    endtask

    task automatic t_unused_src();
        flush();
        drv(5'd1, 5'd0, 1'b1, 1'b0, 5'd12, 1'b1, 1'b1);
        tick();
        drv(5'd12, 5'd3, 1'b0, 1'b1, 5'd13, 1'b1, 1'b0);
        chk("R10 unused source no stall", {31'd0, stall}, 32'd0);
        tick();
        chk("R10 unused source no bypass", {30'd0, sel_a}, 32'd0);
        chk("R10 unused source value", op_a, V_RF_A);
    endtask

    task automatic t_no_forward();
        flush();
        drv(5'd1, 5'd0, 1'b1, 1'b0, 5'd10, 1'b1, 1'b0);
        tick();
        drv(5'd10, 5'd0, 1'b1, 1'b0, 5'd14, 1'b1, 1'b0);
        chk("R11 stall cycle 1", {31'd0, nf_stall}, 32'd1);
        tick();
        chk("R11 stall cycle 2", {31'd0, nf_stall}, 32'd1);
        chk("R11 bubble in execute", {31'd0, nf_we}, 32'd0);
        tick();
        chk("R11 stall released", {31'd0, nf_stall}, 32'd0);
        tick();
        chk("R11 select stays regfile", {30'd0, nf_sel_a}, 32'd0);
        chk("R11 consumer in execute", {27'd0, nf_rd}, 32'd14);
    endtask

    initial begin
        t_reset();
        t_exmem_alu();
        t_memwb_alu();
        t_memwb_load();
        t_load_use();
        t_priority();
        t_reg_zero();
        t_distance3();
        t_unused_src();
        t_no_forward();
        flush();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule